// File: doc/BRIEF.md
# Sign-Magnitude Binary/Decimal Adder-Subtractor

This block adds or subtracts two operands held either as plain binary words or as packed 8421 BCD digits. The operands may be unsigned or sign-magnitude. In every case the result comes back as a true magnitude with its own sign, so a caller never has to re-complement a negative difference, even when the subtrahend is the larger of the two. The effective operation is derived from the two operand signs and the add/subtract request.

Two pieces of logic run side by side. A magnitude comparator, built as a generate/propagate carry chain over the two magnitudes, feeds its carry straight into the adder as carry-in. The adder produces either a finished difference or a one's/nine's-complement image of it. A final conditional complement turns that image into the true magnitude, so no second subtraction pass is needed. In decimal mode the subtrahend's nine's complement is formed as a one's complement followed by a digit-wise subtraction of six, and each digit sum above nine receives a +6 correction. The result and the overflow flag are registered, so the outputs appear one clock after the inputs.

Top module: `sm_addsub`

## Requirements
- R1: A synchronous active-high reset clears `result` and `ovf` to zero. Outside reset, both outputs reflect the inputs sampled at the previous rising clock edge.
- R2: Each operand's effective sign is its bit W-1 ANDed with `signed_mode`. The block performs effective addition exactly when the XOR of the two effective signs and `sub_req` (0 = add, 1 = subtract) is 0; otherwise it performs effective subtraction on the magnitudes.
- R3: For effective addition, the result magnitude is the sum of the magnitudes modulo the magnitude range, and the result takes the first operand's effective sign.
- R4: For effective subtraction with |A| > |B|, the result magnitude is |A| - |B| and the result takes the first operand's effective sign.
- R5: For effective subtraction with |A| < |B|, the result magnitude is |B| - |A| and the sign is the inverse of the first operand's effective sign. In unsigned mode this leaves the absolute difference in `result`.
- R6: A zero result magnitude (for example, equal magnitudes under effective subtraction) always carries sign bit 0.
- R7: With `bin_mode` = 0, every 4-bit nibble is a BCD digit 0..9 (bits 4k+3..4k hold digit k, digit 0 least significant). All result digits are valid BCD, and the arithmetic is decimal with carries between digits.
- R8: In signed decimal mode, the top nibble is a sign digit: bit W-1 is the sign and bits W-2..W-4 are ignored. The magnitude has DIGITS-1 digits, and the result's sign digit is 0000 or 1000.
- R9: `ovf` is 1 only when effective addition carries out of the magnitude field: bit W-1 in signed binary, bit W-4 (the top magnitude digit) in signed decimal, and the full width in unsigned mode. Effective subtraction never raises it.
- R10: In signed binary mode, bit W-1 is the sign and bits W-2..0 are the magnitude. In unsigned mode, all W bits are magnitude in both number systems.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 4*DIGITS | First operand (minuend / augend) |
| opnd_b | input | 4*DIGITS | Second operand (subtrahend / addend) |
| sub_req | input | 1 | 0 requests addition, 1 requests subtraction |
| signed_mode | input | 1 | 1 treats bit W-1 as a sign bit |
| bin_mode | input | 1 | 1 selects binary, 0 selects 8421 BCD |
| result | output | 4*DIGITS | Registered sign-magnitude result |
| ovf | output | 1 | Registered carry-out of the magnitude field on effective addition |

## Verification
The decimal assertions assume that both operands hold only digits 0..9 whenever `bin_mode` is 0. The checker samples this condition and makes the digit-validity property conditional on it. Every decimal stimulus in the bench is built digit by digit from the range 0..9, so that condition always holds. Sign-digit filler bits are the one exception: in signed decimal mode they are set deliberately to show that the block ignores them. Binary sweeps use arbitrary words because any bit pattern is a legal binary operand.

// File: rtl/smadd_pkg.sv
`timescale 1ns/1ps
package smadd_pkg;

  // Subtract six from one nibble; valid for inputs 6..15.
  function automatic logic [3:0] nib_minus6(input logic [3:0] x);
    logic [3:0] r;
    r[0] = x[0];
    r[1] = ~x[1];
    r[2] = x[2] ^ x[1];
    r[3] = x[3] & x[2] & x[1];
    return r;
  endfunction

endpackage

// File: rtl/smadd_cmp.sv
`timescale 1ns/1ps
// Strict magnitude comparison as the carry of x + ~y.
module smadd_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         gt
);
  logic [W-1:0] gen, prop;

  assign gen  = x & ~y;
  assign prop = x | ~y;

  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      c = gen[i] | (prop[i] & c);
    end
    gt = c;
  end
endmodule

// File: rtl/smadd_nines.sv
`timescale 1ns/1ps
// Digit-wise nine's complement: one's complement, then minus six per nibble.
module smadd_nines #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] din,
  output logic [4*DIGITS-1:0] dout
);
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    assign dout[4*d +: 4] = smadd_pkg::nib_minus6(~din[4*d +: 4]);
  end
endmodule

// File: rtl/smadd_digit_add.sv
`timescale 1ns/1ps
// Shared adder: plain binary carry-propagate, or BCD with per-digit +6 fix.
module smadd_digit_add #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] x,
  input  logic [4*DIGITS-1:0] y,
  input  logic                cin,
  input  logic                dec_en,
  output logic [4*DIGITS:0]   sum
);
  localparam int W = 4 * DIGITS;

  logic [W:0]      bin_sum;
  logic [W-1:0]    dec_sum;
  logic [DIGITS:0] dc;

  assign bin_sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign dc[0]   = cin;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    logic [4:0] s5;
    logic [4:0] t5;
    logic       dgen, dprop;
    assign s5    = {1'b0, x[4*d +: 4]} + {1'b0, y[4*d +: 4]};
    assign dgen  = (s5 > 5'd9);
    assign dprop = (s5 == 5'd9);
    assign dc[d+1] = dgen | (dprop & dc[d]);
    assign t5 = s5 + {4'd0, dc[d]} + (dc[d+1] ? 5'd6 : 5'd0);
    assign dec_sum[4*d +: 4] = t5[3:0];
  end

  assign sum = dec_en ? {dc[DIGITS], dec_sum} : bin_sum;
endmodule

// File: rtl/sm_addsub.sv
`timescale 1ns/1ps
module sm_addsub #(
  parameter int DIGITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [4*DIGITS-1:0] opnd_a,
  input  logic [4*DIGITS-1:0] opnd_b,
  input  logic                sub_req,
  input  logic                signed_mode,
  input  logic                bin_mode,
  output logic [4*DIGITS-1:0] result,
  output logic                ovf
);
  localparam int W = 4 * DIGITS;

  logic         sa, sb, eadd, gt, co, sc, zero, sign, carry_sel;
  logic [W-1:0] mask, ma, mb, b_n9, add_y, raw, raw_n9, mag_out, res_d;
  logic [W:0]   sum_full;

  // Effective signs and operation
  assign sa   = opnd_a[W-1] & signed_mode;
  assign sb   = opnd_b[W-1] & signed_mode;
  assign eadd = ~(sa ^ sb ^ sub_req);

  // Magnitude field
  always_comb begin
    if (!signed_mode)  mask = '1;
    else if (bin_mode) mask = {1'b0, {(W-1){1'b1}}};
    else               mask = {4'b0000, {(W-4){1'b1}}};
  end
  assign ma = opnd_a & mask;
  assign mb = opnd_b & mask;

  // Ordering, computed beside the adder
  smadd_cmp #(.W(W)) u_cmp (.x(ma), .y(mb), .gt(gt));
  assign co = gt & ~eadd;

  // Subtrahend conditioning
  smadd_nines #(.DIGITS(DIGITS)) u_nb (.din(mb), .dout(b_n9));
  always_comb begin
    if (eadd)          add_y = mb;
    else if (bin_mode) add_y = ~mb & mask;
    else               add_y = b_n9 & mask;
  end

  smadd_digit_add #(.DIGITS(DIGITS)) u_add (
    .x(ma), .y(add_y), .cin(co), .dec_en(~bin_mode), .sum(sum_full)
  );

  always_comb begin
    if (!signed_mode)  carry_sel = sum_full[W];
    else if (bin_mode) carry_sel = sum_full[W-1];
    else               carry_sel = sum_full[W-4];
  end

  // Final conditional complement
  assign raw = sum_full[W-1:0] & mask;
  smadd_nines #(.DIGITS(DIGITS)) u_nr (.din(raw), .dout(raw_n9));
  assign sc = ~eadd & ~co;

  always_comb begin
    if (!sc)           mag_out = raw;
    else if (bin_mode) mag_out = ~raw & mask;
    else               mag_out = raw_n9 & mask;
  end

  assign zero = (mag_out == '0);
  assign sign = (sa ^ sc) & ~zero;

  always_comb begin
    res_d = mag_out;
    if (signed_mode) res_d[W-1] = sign;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      result <= res_d;
      ovf    <= eadd & carry_sel;
    end
  end
endmodule

// File: rtl/sm_addsub_chk.sv
`timescale 1ns/1ps
module sm_addsub_chk #(
  parameter int DIGITS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [4*DIGITS-1:0] opnd_a,
  input logic [4*DIGITS-1:0] opnd_b,
  input logic                sub_req,
  input logic                signed_mode,
  input logic                bin_mode,
  input logic [4*DIGITS-1:0] result,
  input logic                ovf
);
  localparam int W = 4 * DIGITS;

  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic primed;
  logic in_eadd, in_bcd, in_eq_usub;

  always_ff @(posedge clk) primed <= ~rst;

  assign in_eadd    = ~((opnd_a[W-1] & signed_mode) ^ (opnd_b[W-1] & signed_mode) ^ sub_req);
  assign in_bcd     = all_bcd(opnd_a) & all_bcd(opnd_b);
  assign in_eq_usub = ~signed_mode & sub_req & (opnd_a == opnd_b);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0 && !ovf));

  a_r9_ovf_only_add: assert property (@(posedge clk) disable iff (rst)
    (primed && ovf) |-> $past(in_eadd));

  a_r6_zero_positive: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(signed_mode) && result[W-2:0] == '0) |-> !result[W-1]);

  a_r7_digits_bcd: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(bin_mode) && $past(in_bcd)) |-> all_bcd(result));

  a_r5_equal_unsigned_zero: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(in_eq_usub)) |-> (result == '0 && !ovf));

  a_r8_sign_digit: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(signed_mode) && !$past(bin_mode)) |-> result[W-2:W-4] == 3'b000);
endmodule

bind sm_addsub sm_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .sub_req(sub_req),
  .signed_mode(signed_mode), .bin_mode(bin_mode), .result(result), .ovf(ovf)
);

// File: tb/sim_sm_addsub.sv
`timescale 1ns/1ps
module sim_sm_addsub;
  localparam int ND = 2;
  localparam int W  = 4 * ND;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic         sub_req = 1'b0, signed_mode = 1'b0, bin_mode = 1'b1;
  logic [W-1:0] result;
  logic         ovf;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #2.5 clk = ~clk;

  sm_addsub #(.DIGITS(ND)) u0 (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .sub_req(sub_req),
    .signed_mode(signed_mode), .bin_mode(bin_mode), .result(result), .ovf(ovf)
  );

  function automatic int bcd2int(input logic [W-1:0] v, input int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] int2bcd(input int v, input int nd);
    logic [W-1:0] r = '0;
    int t = v;
    for (int i = 0; i < nd; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic sub, input logic sg, input logic bn);
    int ma, mb, modv, mag, nd;
    bit sa, sb, ea, neg, exp_ovf;
    logic [W-1:0] exp_res;
    string tag;
    opnd_a = a; opnd_b = b; sub_req = sub; signed_mode = sg; bin_mode = bn;
    @(negedge clk);
    // R2: effective signs and effective operation
    sa = a[W-1] & sg;
    sb = b[W-1] & sg;
    ea = !(sa ^ sb ^ sub);
    if (bn) begin  // R10: binary field layout
      modv = sg ? (1 << (W-1)) : (1 << W);
      ma = int'(a) % modv;
      mb = int'(b) % modv;
      nd = 0;
    end else begin // R7/R8: decimal digits, sign digit in signed mode
      nd = sg ? ND - 1 : ND;
      modv = 1;
      for (int i = 0; i < nd; i++) modv = modv * 10;
      ma = bcd2int(a, nd);
      mb = bcd2int(b, nd);
    end
    exp_ovf = 1'b0;
    if (ea) begin
      mag = ma + mb;
      exp_ovf = (mag >= modv);
      mag = mag % modv;
      neg = sa;
    end else if (ma > mb) begin
      mag = ma - mb; neg = sa;
    end else begin
      mag = mb - ma; neg = !sa;
    end
    if (mag == 0) neg = 1'b0;
    exp_res = bn ? mag[W-1:0] : int2bcd(mag, nd);
    if (sg) exp_res[W-1] = neg;

    if (mag == 0 && !ea)       tag = "R6";
    else if (sg && sa != sb)   tag = "R2";
    else if (!bn && sg)        tag = "R8";
    else if (!bn)              tag = "R7";
    else if (sg)               tag = "R10";
    else if (ea)               tag = "R3";
    else if (ma > mb)          tag = "R4";
    else                       tag = "R5";

    compared++;
    if (result !== exp_res) begin
      mismatched++;
      $display("FAIL %s result a=%h b=%h sub=%0d sg=%0d bin=%0d got %h expected %h",
               tag, a, b, sub, sg, bn, result, exp_res);
    end
    compared++;
    if (ovf !== exp_ovf) begin
      mismatched++;
      $display("FAIL R9 ovf a=%h b=%h sub=%0d sg=%0d bin=%0d got %0d expected %0d",
               a, b, sub, sg, bn, ovf, exp_ovf);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with active inputs
    opnd_a = 8'h99; opnd_b = 8'h99; bin_mode = 1'b1;
    repeat (3) @(negedge clk);
    compared++;
    if (result !== '0 || ovf !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset got %h/%0d expected 00/0", result, ovf);
    end
    rst = 1'b0;

    // Binary sweeps, unsigned and signed (R3 R4 R5 R10)
    for (int sg = 0; sg < 2; sg++)
      for (int sub = 0; sub < 2; sub++)
        for (int a = 0; a < 256; a += 3)
          for (int b = 0; b < 256; b += 3)
            run(W'(a), W'(b), 1'(sub), 1'(sg), 1'b1);

    // Equal magnitudes with opposite signs, plus negative zero (R6)
    for (int sub = 0; sub < 2; sub++)
      for (int m = 0; m < 128; m += 9) begin
        run(W'(m), W'(m | 128), 1'(sub), 1'b1, 1'b1);
        run(W'(m | 128), W'(m), 1'(sub), 1'b1, 1'b1);
      end
    run(8'h80, 8'h00, 1'b0, 1'b1, 1'b1);

    // Unsigned decimal, every BCD pair (R7 R9)
    for (int sub = 0; sub < 2; sub++)
      for (int a = 0; a < 100; a++)
        for (int b = 0; b < 100; b++)
          run(int2bcd(a, ND), int2bcd(b, ND), 1'(sub), 1'b0, 1'b0);

    // Signed decimal: sign digit 0/1 positive, 8/9 negative, low bits ignored (R8)
    for (int sub = 0; sub < 2; sub++)
      for (int ta = 0; ta < 4; ta++)
        for (int da = 0; da < 10; da++)
          for (int tb = 0; tb < 4; tb++)
            for (int db = 0; db < 10; db++) begin
              logic [3:0] sda, sdb;
              sda = (ta == 0) ? 4'h0 : (ta == 1) ? 4'h1 : (ta == 2) ? 4'h8 : 4'h9;
              sdb = (tb == 0) ? 4'h0 : (tb == 1) ? 4'h1 : (tb == 2) ? 4'h8 : 4'h9;
              run({sda, 4'(da)}, {sdb, 4'(db)}, 1'(sub), 1'b1, 1'b0);
            end

    finish_run();
  end
endmodule